// File: doc/BRIEF.md
# Systolic Bit-Serial Array Multiplier

This block multiplies an unsigned N-bit multiplicand, presented in parallel, by an N-bit multiplier that arrives one bit per clock, least significant bit first. The result leaves as a 2N-bit product, one bit per clock, least significant bit first. A linear row of N cells does the work. Cell i keeps multiplicand bit i fixed for the whole frame and contains one full adder with a local carry register.

No signal in the array drives more than one neighbour. A multiplier bit moves from cell to cell through two registers per hop, so cell i sees a bit 2i cycles after cell 0 sees it. The partial sum moves toward the more significant cell through one register per hop. Under this register placement every full adder in a given cycle adds terms of a single binary weight. The most significant cell delivers each product bit, and the outside behaviour is the same as a multiplier that broadcasts each bit to all cells. A start strobe latches the multiplicand, takes the first multiplier bit and clears the accumulation state.

The user pulses start together with bit 0, gives bits 1..N-1 on the next N-1 cycles, and then reads 2N product bits while the valid flag is high.

Top module: `bsm_systolic_mul`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, prod_valid is 0 and prod_bit is 0.
- R2: For every pair of N-bit unsigned operands, the 2N bits shown while prod_valid is high are the product of the two operands, in order from bit 0 to bit 2N-1.
- R3: If start is high in cycle s, prod_valid is high in exactly cycles s+N+1 through s+3N, and bit k of the product is on prod_bit in cycle s+N+1+k.
- R4: Multiplier bit j is taken from mplier_bit in cycle s+j, for j from 0 to N-1. In every other cycle mplier_bit is ignored, and zeros enter the array in its place.
- R5: The multiplicand is sampled only in a cycle where start is high. Later changes on mcand do not affect the product of the current frame.
- R6: A start in the middle of a frame abandons it. All sum and carry state is cleared, and the new frame produces its correct product with the R3 timing.
- R7: A start in cycle s+3N+1, the cycle right after the last product bit, begins a new frame that is correct with no idle cycle between frames.
- R8: prod_bit is 0 in every cycle where prod_valid is 0.
- R9: The multiplier bit held by cell i (i > 0) equals the bit held by cell i-1 two cycles earlier, as long as no start occurred in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame strobe: latches mcand, takes multiplier bit 0, clears the array |
| mcand | input | N | Parallel unsigned multiplicand |
| mplier_bit | input | 1 | Serial multiplier bit, least significant first |
| prod_bit | output | 1 | Serial product bit, least significant first |
| prod_valid | output | 1 | High during the 2N cycles that carry product bits |

## Verification
The bound checker checks the following on every cycle:
- the valid window, measured from its own count of cycles since start;
- a quiet output outside that window;
- zero insertion into the array once the multiplier bits have been taken;
- the multiplicand register holding steady between strobes;
- the sum chain being cleared after a strobe;
- the two-cycle step of the multiplier bit from cell to cell.

Only the bench scenarios can show that the serial bits really form the product. The bench covers all operand pairs, frames run back to back, frames cut short by a new strobe, and noise on mcand and mplier_bit outside their sampling cycles.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FEED,
    PH_DRAIN,
    PH_EMIT
  } phase_e;

  function automatic logic fa_sum(input logic p, input logic q, input logic r);
    return p ^ q ^ r;
  endfunction

  function automatic logic fa_carry(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  // cycles from the start cycle to the last product bit
  function automatic int span_cycles(input int n);
    return 3 * n;
  endfunction

  // age (cycles after start) of the first product bit
  function automatic int first_emit_age(input int n);
    return n + 1;
  endfunction

endpackage

// File: rtl/bsm_frame_ctl.sv
module bsm_frame_ctl
  import bsm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic x_in,
  output logic x_feed,
  output logic emit
);
  localparam int SPAN = span_cycles(N);
  localparam int FIRST = first_emit_age(N);
  localparam int AW = $clog2(SPAN + 1);

  logic [AW-1:0] age_q;
  phase_e        phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (start) begin
      age_q <= AW'(1);
    end else if (age_q == AW'(SPAN)) begin
      age_q <= '0;
    end else if (age_q != '0) begin
      age_q <= age_q + AW'(1);
    end
  end

  always_comb begin
    if (age_q == '0) begin
      phase = PH_IDLE;
    end else if (age_q < AW'(N)) begin
      phase = PH_FEED;
    end else if (age_q < AW'(FIRST)) begin
      phase = PH_DRAIN;
    end else begin
      phase = PH_EMIT;
    end
  end

  assign x_feed = (start || phase == PH_FEED) ? x_in : 1'b0;
  assign emit   = (phase == PH_EMIT);

endmodule

// File: rtl/bsm_cell.sv
module bsm_cell
  import bsm_pkg::*;
#(
  parameter bit HEAD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic a_bit,
  input  logic x_up,
  input  logic s_up,
  output logic x_tap,
  output logic s_down
);
  logic x_cur_q;
  logic sum_q;
  logic carry_q;
  logic pp;
  logic fs;
  logic fc;

  assign pp = a_bit & x_cur_q;
  assign fs = fa_sum(pp, s_up, carry_q);
  assign fc = fa_carry(pp, s_up, carry_q);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      sum_q   <= fs;
      carry_q <= fc;
    end
  end

  generate
    if (HEAD) begin : g_head
      // first cell: one register from the feed, loads bit 0 on the strobe
      always_ff @(posedge clk) begin
        if (rst) begin
          x_cur_q <= 1'b0;
        end else begin
          x_cur_q <= x_up;
        end
      end
    end else begin : g_body
      logic x_mid_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          x_mid_q <= 1'b0;
          x_cur_q <= 1'b0;
        end else begin
          x_mid_q <= x_up;
          x_cur_q <= x_mid_q;
        end
      end
    end
  endgenerate

  assign x_tap  = x_cur_q;
  assign s_down = sum_q;

endmodule

// File: rtl/bsm_systolic_mul.sv
module bsm_systolic_mul
  import bsm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] mcand,
  input  logic         mplier_bit,
  output logic         prod_bit,
  output logic         prod_valid
);
  logic         x_feed;
  logic         emit;
  logic [N-1:0] mcand_q;
  logic [N-1:0] sum_chain;
  logic [N-1:0] x_tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
    end else if (start) begin
      mcand_q <= mcand;
    end
  end

  bsm_frame_ctl #(.N(N)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .x_in   (mplier_bit),
    .x_feed (x_feed),
    .emit   (emit)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_first
        bsm_cell #(.HEAD(1'b1)) u_cell (
          .clk    (clk),
          .rst    (rst),
          .clr    (start),
          .a_bit  (mcand_q[i]),
          .x_up   (x_feed),
          .s_up   (1'b0),
          .x_tap  (x_tap[i]),
          .s_down (sum_chain[i])
        );
      end else begin : g_next
        bsm_cell #(.HEAD(1'b0)) u_cell (
          .clk    (clk),
          .rst    (rst),
          .clr    (start),
          .a_bit  (mcand_q[i]),
          .x_up   (x_tap[i-1]),
          .s_up   (sum_chain[i-1]),
          .x_tap  (x_tap[i]),
          .s_down (sum_chain[i])
        );
      end
    end
  endgenerate

  assign prod_valid = emit;
  assign prod_bit   = emit & sum_chain[N-1];

endmodule

// File: rtl/bsm_systolic_mul_chk.sv
module bsm_systolic_mul_chk
  import bsm_pkg::*;
#(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         prod_bit,
  input logic         prod_valid,
  input logic         x_feed,
  input logic [N-1:0] mcand_q,
  input logic [N-1:0] sum_chain,
  input logic [N-1:0] x_tap
);
  localparam int SPAN = span_cycles(N);
  localparam int FIRST = first_emit_age(N);
  localparam int AW = $clog2(SPAN + 1);

  logic [AW-1:0] age_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_c <= '0;
    end else if (start) begin
      age_c <= AW'(1);
    end else if (age_c != '0 && age_c < AW'(SPAN)) begin
      age_c <= age_c + AW'(1);
    end else begin
      age_c <= '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!prod_valid && !prod_bit));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !prod_valid |-> !prod_bit);

  // R3
  valid_window_chk: assert property (@(posedge clk) disable iff (rst)
    prod_valid == (age_c >= AW'(FIRST)));

  // R4
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && (age_c == '0 || age_c >= AW'(N))) |-> !x_feed);

  // R5
  mcand_hold_chk: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(mcand_q));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst) start |=> (sum_chain == '0));

  generate
    for (genvar i = 1; i < N; i++) begin : g_hop
      // R9
      x_hop_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(start, 2)) |-> (x_tap[i] == $past(x_tap[i-1], 2)));
    end
  endgenerate

endmodule

bind bsm_systolic_mul bsm_systolic_mul_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .prod_bit   (prod_bit),
  .prod_valid (prod_valid),
  .x_feed     (x_feed),
  .mcand_q    (mcand_q),
  .sum_chain  (sum_chain),
  .x_tap      (x_tap)
);

// File: tb/bsm_systolic_mul_test.sv
module bsm_systolic_mul_test;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic         mplier_bit = 1'b0;
  logic         prod_bit;
  logic         prod_valid;

  int          total = 0;
  int          bad = 0;
  int unsigned cyc = 0;
  int          exp_q[$];
  int unsigned when_q[$];
  string       tag_q[$];
  logic [PW-1:0] got = '0;
  int          idx = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bsm_systolic_mul #(.N(W)) uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mcand      (mcand),
    .mplier_bit (mplier_bit),
    .prod_bit   (prod_bit),
    .prod_valid (prod_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // monitor: sample away from the rising edge, reassemble and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (prod_valid) begin
        if (idx == 0) begin
          int unsigned w;
          w = (when_q.size() != 0) ? when_q.pop_front() : 0;
          check(cyc == w, "R3 first bit cycle", cyc, w);
        end
        got[idx] = prod_bit;
        idx++;
        if (idx == PW) begin
          int e;
          string t;
          e = (exp_q.size() != 0) ? exp_q.pop_front() : -1;
          t = (tag_q.size() != 0) ? tag_q.pop_front() : "R2";
          check(int'(got) == e, t, int'(got), e);
          idx = 0;
        end
      end else begin
        check(prod_bit == 1'b0, "R8 idle output", prod_bit, 0);
        check(idx == 0, "R3 valid run length", idx, 0);
        idx = 0;
      end
    end
  end

  // driver: caller sits in the cycle that gets the strobe
  task automatic run_frame(input int a, input int x, input int gap, input string tag);
    start = 1'b1;
    mcand = W'(a);
    mplier_bit = x[0];
    exp_q.push_back(a * x);
    when_q.push_back(cyc + W + 1);
    tag_q.push_back(tag);
    for (int j = 1; j <= 3 * W; j++) begin
      tick();
      start = 1'b0;
      mcand = W'($urandom);
      mplier_bit = (j < W) ? x[j] : 1'($urandom);
    end
    tick();
    for (int g = 0; g < gap; g++) begin
      start = 1'b0;
      mplier_bit = 1'($urandom);
      mcand = W'($urandom);
      tick();
    end
  endtask

  task automatic abort_frame(input int a, input int x);
    start = 1'b1;
    mcand = W'(a);
    mplier_bit = x[0];
    tick();
    start = 1'b0;
    mplier_bit = x[1];
    tick();
  endtask

  initial begin
    repeat (4) tick();
    @(negedge clk);
    check(!prod_valid && !prod_bit, "R1 in reset", {prod_valid, prod_bit}, 0);
    tick();
    rst = 1'b0;
    tick();
    @(negedge clk);
    check(!prod_valid && !prod_bit, "R1 after reset", {prod_valid, prod_bit}, 0);
    tick();
    for (int a = 0; a < (1 << W); a++) begin
      for (int x = 0; x < (1 << W); x++) begin
        int gap;
        gap = ((a * 16 + x) % 37 == 0) ? 3 : 0;
        run_frame(a, x, gap, (gap == 0) ? "R2/R4/R5/R7/R9 product" : "R2/R4/R5 product");
      end
    end
    abort_frame(15, 15);
    run_frame(9, 13, 0, "R6 product after abort");
    abort_frame(15, 7);
    run_frame(15, 15, 0, "R6 product after abort");
    abort_frame(11, 14);
    run_frame(0, 0, 2, "R6 product after abort");
    repeat (3 * W + 5) tick();
    check(exp_q.size() == 0, "R2 frames outstanding", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule